// File: doc/BRIEF.md
# Polynomial-Counter Tone Channel

This block is one channel of a simple sound generator. It turns a slow base tick, arriving at twice the horizontal line rate (near 30 kHz), into a 4-bit amplitude. Three small write-only registers set its behaviour: a waveform select, a 5-bit frequency divisor and a 4-bit volume. The channel first divides the base tick by the divisor plus one. Each divided tick, called a step, advances the waveform source chosen by the select.

The sources are linear-feedback shift registers of 4, 5 and 9 bits, a fixed divider whose modulus depends on the select, and a constant high level. Some selects chain two sources, so that one source decides when the other advances. The output is the volume value while the waveform bit is 1, and zero while it is 0. A full sound system uses two instances and mixes their outputs outside this block.

Top module: `snd_channel`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `amp` is 0. Reset sets the waveform select, divisor and volume registers to 0 and loads every shift register with all ones.
- R2: A write with `wr_en` high stores `wr_data[3:0]` as the waveform select when `wr_addr`=0, `wr_data[4:0]` as the divisor when `wr_addr`=1, and `wr_data[3:0]` as the volume when `wr_addr`=2. A step occurs on every (divisor+1)-th cycle in which `tick_en` is high. Cycles with `tick_en` low neither count nor step, so the waveform holds.
- R3: `amp` is registered. It equals the volume while the waveform bit is 1 and is 0 otherwise. A volume write becomes visible on `amp` one clock after the register captures it.
- R4: Selects 0 and 11 hold the waveform bit at 1, so `amp` follows the volume.
- R5: Select 1 uses the 4-bit shift register (period 15 steps, 8 high). Select 9 uses the 5-bit one (period 31 steps, 16 high). Select 8 uses the 9-bit one (period 511 steps, 256 high).
- R6: Select 2 advances the 4-bit shift register once every 15 steps (period 225 steps, 120 high). Select 3 advances it only on steps where the 5-bit register's output is 1 (period 465 steps).
- R7: Selects 4 and 5 divide by 2 (1 of 2 steps high). Selects 6 and 10 divide by 31 (15 high). Selects 12 and 13 divide by 6 (3 high). Select 14 divides by 93 (46 high).
- R8: Selects 7 and 15 advance the divide-by-2 and divide-by-6 divider respectively, only on steps where the 5-bit register's output is 1. This gives periods of 31 and 93 steps, each containing both levels.
- R9: A write with `wr_addr`=3 changes nothing. A volume of 0 keeps `amp` at 0 under every select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Base tick enable, one cycle per base period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 waveform, 1 divisor, 2 volume |
| wr_data | input | 5 | Write data |
| amp | output | 4 | Gated amplitude output |

## Verification
The checker watches, on every cycle, that `amp` is either zero or the volume of the cycle before. It also checks that constant selects and a zero volume behave as specified, that the tick counter freezes without `tick_en` and otherwise climbs by one, and that no shift register ever reaches the all-zero state. Periods and duty of each waveform span hundreds of cycles, so only the bench's scenarios show them. For every select, the bench measures the repeat length and the high count of the output in clock cycles and compares them with the step figures multiplied by (divisor+1).

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int CTRL_W = 4;
  localparam int MOD_W  = 7;

  typedef enum logic [2:0] {SRC_ONE, SRC_P4, SRC_P5, SRC_P9, SRC_DIV} src_e;

  typedef struct packed {
    src_e             src;
    logic             p4_by_div;  // 4-bit register steps on divider wrap
    logic             p4_by_p5;   // 4-bit register steps when 5-bit output is 1
    logic             div_by_p5;  // divider steps when 5-bit output is 1
    logic [MOD_W-1:0] modulus;
  } mode_t;

  function automatic mode_t decode_mode(input logic [CTRL_W-1:0] c);
    mode_t m;
    m = '{src: SRC_ONE, p4_by_div: 1'b0, p4_by_p5: 1'b0, div_by_p5: 1'b0,
          modulus: MOD_W'(2)};
    case (c)
      4'd1:         m.src = SRC_P4;
      4'd2:         begin m.src = SRC_P4; m.p4_by_div = 1'b1; m.modulus = MOD_W'(15); end
      4'd3:         begin m.src = SRC_P4; m.p4_by_p5 = 1'b1; end
      4'd4, 4'd5:   m.src = SRC_DIV;
      4'd6, 4'd10:  begin m.src = SRC_DIV; m.modulus = MOD_W'(31); end
      4'd7:         begin m.src = SRC_DIV; m.div_by_p5 = 1'b1; end
      4'd8:         m.src = SRC_P9;
      4'd9:         m.src = SRC_P5;
      4'd12, 4'd13: begin m.src = SRC_DIV; m.modulus = MOD_W'(6); end
      4'd14:        begin m.src = SRC_DIV; m.modulus = MOD_W'(93); end
      4'd15:        begin m.src = SRC_DIV; m.modulus = MOD_W'(6); m.div_by_p5 = 1'b1; end
      default:      m.src = SRC_ONE;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/snd_prescale.sv
module snd_prescale #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic [W-1:0] limit,
  output logic         step,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  assign step  = tick_en && (cnt_q >= limit);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (step)    cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/snd_lfsr.sv
module snd_lfsr #(
  parameter int W   = 4,
  parameter int TAP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic         bit_o,
  output logic [W-1:0] state_o
);
  logic [W-1:0] s_q;

  assign bit_o   = s_q[W-1];
  assign state_o = s_q;

  always_ff @(posedge clk) begin
    if (rst)      s_q <= '1;
    else if (adv) s_q <= {s_q[W-2:0], s_q[W-1] ^ s_q[TAP]};
  end
endmodule

// File: rtl/snd_divider.sv
module snd_divider #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] modulus,
  output logic         wrap,
  output logic         bit_o
);
  logic [W-1:0] cnt_q;

  assign wrap  = (cnt_q >= modulus - 1'b1);
  assign bit_o = (cnt_q < (modulus >> 1));

  always_ff @(posedge clk) begin
    if (rst)      cnt_q <= '0;
    else if (adv) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/snd_channel.sv
module snd_channel
  import snd_pkg::*;
#(
  parameter int FREQ_W = 5,
  parameter int VOL_W  = 4,
  parameter int DATA_W = 5,
  parameter int P4_W   = 4,
  parameter int P4_TAP = 2,
  parameter int P5_W   = 5,
  parameter int P5_TAP = 2,
  parameter int P9_W   = 9,
  parameter int P9_TAP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [VOL_W-1:0]  amp
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [FREQ_W-1:0] freq_q;
  logic [VOL_W-1:0]  vol_q;
  logic [FREQ_W-1:0] pre_q;
  logic              step;
  mode_t             mode;
  logic              p4_bit, p5_bit, p9_bit, div_bit, div_wrap;
  logic              p4_adv, div_adv, wave;
  logic [P4_W-1:0]   p4_s;
  logic [P5_W-1:0]   p5_s;
  logic [P9_W-1:0]   p9_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      freq_q <= '0;
      vol_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0:    ctrl_q <= wr_data[CTRL_W-1:0];
        2'd1:    freq_q <= wr_data[FREQ_W-1:0];
        2'd2:    vol_q  <= wr_data[VOL_W-1:0];
        default: ;
      endcase
    end
  end

  assign mode = decode_mode(ctrl_q);

  snd_prescale #(.W(FREQ_W)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .limit(freq_q),
    .step(step), .cnt_o(pre_q)
  );

  assign div_adv = step && (!mode.div_by_p5 || p5_bit);
  assign p4_adv  = step && (mode.p4_by_div ? div_wrap :
                            mode.p4_by_p5  ? p5_bit   : 1'b1);

  snd_divider #(.W(MOD_W)) u_div (
    .clk(clk), .rst(rst), .adv(div_adv), .modulus(mode.modulus),
    .wrap(div_wrap), .bit_o(div_bit)
  );

  snd_lfsr #(.W(P4_W), .TAP(P4_TAP)) u_p4 (
    .clk(clk), .rst(rst), .adv(p4_adv), .bit_o(p4_bit), .state_o(p4_s)
  );
  snd_lfsr #(.W(P5_W), .TAP(P5_TAP)) u_p5 (
    .clk(clk), .rst(rst), .adv(step), .bit_o(p5_bit), .state_o(p5_s)
  );
  snd_lfsr #(.W(P9_W), .TAP(P9_TAP)) u_p9 (
    .clk(clk), .rst(rst), .adv(step), .bit_o(p9_bit), .state_o(p9_s)
  );

  always_comb begin
    case (mode.src)
      SRC_P4:  wave = p4_bit;
      SRC_P5:  wave = p5_bit;
      SRC_P9:  wave = p9_bit;
      SRC_DIV: wave = div_bit;
      default: wave = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) amp <= '0;
    else     amp <= wave ? vol_q : '0;
  end
endmodule

// File: rtl/snd_channel_chk.sv
module snd_channel_chk #(
  parameter int FREQ_W = 5,
  parameter int VOL_W  = 4,
  parameter int P4_W   = 4,
  parameter int P5_W   = 5,
  parameter int P9_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic [3:0]        ctrl_q,
  input logic [FREQ_W-1:0] freq_q,
  input logic [VOL_W-1:0]  vol_q,
  input logic [FREQ_W-1:0] pre_q,
  input logic [P4_W-1:0]   p4_s,
  input logic [P5_W-1:0]   p5_s,
  input logic [P9_W-1:0]   p9_s,
  input logic [VOL_W-1:0]  amp
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> amp == '0)
    else $error("p_reset_clear_r1");

  p_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pre_q))
    else $error("p_tick_hold_r2");

  p_tick_count_r2: assert property (@(posedge clk) disable iff (rst)
    (tick_en && pre_q < freq_q) |=> pre_q == $past(pre_q) + 1'b1)
    else $error("p_tick_count_r2");

  p_amp_level_r3: assert property (@(posedge clk) disable iff (rst)
    amp != '0 |-> amp == $past(vol_q))
    else $error("p_amp_level_r3");

  p_const_mode_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q) == 4'd0 || $past(ctrl_q) == 4'd11) |-> amp == $past(vol_q))
    else $error("p_const_mode_r4");

  p_lfsr_live_r5: assert property (@(posedge clk) disable iff (rst)
    p4_s != '0 && p5_s != '0 && p9_s != '0)
    else $error("p_lfsr_live_r5");

  p_silent_r9: assert property (@(posedge clk) disable iff (rst)
    $past(vol_q) == '0 |-> amp == '0)
    else $error("p_silent_r9");
endmodule

bind snd_channel snd_channel_chk u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .ctrl_q(ctrl_q), .freq_q(freq_q),
  .vol_q(vol_q), .pre_q(pre_q), .p4_s(p4_s), .p5_s(p5_s), .p9_s(p9_s),
  .amp(amp)
);

// File: tb/tb_snd_channel.sv
`timescale 1ns/1ps
module tb_snd_channel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [4:0] wr_data = '0;
  logic [3:0] amp;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit samp [0:1023];

  always #5 clk = ~clk;

  snd_channel dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .amp(amp)
  );

  // {ctrl[28:25], freq[24:20], period_steps[19:10], high_steps[9:0]}; 1023 = mixed
  localparam logic [28:0] VEC [16] = '{
    {4'd0,  5'd2,  10'd1,   10'd1},
    {4'd1,  5'd1,  10'd15,  10'd8},
    {4'd2,  5'd0,  10'd225, 10'd120},
    {4'd3,  5'd0,  10'd465, 10'd1023},
    {4'd4,  5'd3,  10'd2,   10'd1},
    {4'd5,  5'd0,  10'd2,   10'd1},
    {4'd6,  5'd1,  10'd31,  10'd15},
    {4'd7,  5'd0,  10'd31,  10'd1023},
    {4'd8,  5'd0,  10'd511, 10'd256},
    {4'd9,  5'd2,  10'd31,  10'd16},
    {4'd10, 5'd0,  10'd31,  10'd15},
    {4'd11, 5'd4,  10'd1,   10'd1},
    {4'd12, 5'd1,  10'd6,   10'd3},
    {4'd13, 5'd31, 10'd6,   10'd3},
    {4'd14, 5'd0,  10'd93,  10'd46},
    {4'd15, 5'd1,  10'd93,  10'd1023}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic string req_of(input int c);
    case (c)
      0, 11:   return "R4";
      1, 8, 9: return "R5";
      2, 3:    return "R6";
      7, 15:   return "R8";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(amp == 4'd0, "R1 amp in reset", amp, 0);
    rst = 1'b0;
    @(negedge clk);
    check(amp == 4'd0, "R1 amp after reset", amp, 0);

    // select resets to 0 (constant), so amp follows volume
    wr(2'd2, 5'd5); @(negedge clk);
    check(amp == 4'd5, "R1 R3 vol 5 with reset select", amp, 5);
    wr(2'd2, 5'd12); @(negedge clk);
    check(amp == 4'd12, "R3 vol 12", amp, 12);
    wr(2'd3, 5'd0); repeat (2) @(negedge clk);
    check(amp == 4'd12, "R9 addr 3 ignored", amp, 12);
    wr(2'd2, 5'd0); @(negedge clk);
    check(amp == 4'd0, "R9 vol 0 silent", amp, 0);

    // R2: no steps while tick_en is low
    wr(2'd2, 5'd15); wr(2'd0, 5'd4); wr(2'd1, 5'd0);
    tick_en = 1'b1;
    repeat (20) @(negedge clk);
    tick_en = 1'b0;
    @(negedge clk);
    begin
      logic [3:0] held;
      int changes;
      held = amp; changes = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (amp != held) changes++;
      end
      check(changes == 0, "R2 hold without tick", changes, 0);
      tick_en = 1'b1;
      @(negedge clk); @(negedge clk);
      check(amp != held, "R2 steps resume", amp, 15 - held);
    end

    // table of waveform selects
    for (int v = 0; v < 16; v++) begin
      int c, f, ps, hs, pc, mism, ones;
      string rq;
      c  = int'(VEC[v][28:25]);
      f  = int'(VEC[v][24:20]);
      ps = int'(VEC[v][19:10]);
      hs = int'(VEC[v][9:0]);
      pc = ps * (f + 1);
      rq = req_of(c);
      wr(2'd0, 5'(c)); wr(2'd1, 5'(f));
      repeat (200) @(negedge clk);
      for (int i = 0; i < 2 * pc; i++) begin
        @(negedge clk);
        samp[i] = (amp != 4'd0);
      end
      mism = 0; ones = 0;
      for (int i = 0; i < pc; i++) begin
        if (samp[i] != samp[i + pc]) mism++;
        if (samp[i]) ones++;
      end
      check(mism == 0, {rq, " period mismatch count"}, mism, 0);
      if (hs != 1023)
        check(ones == hs * (f + 1), {rq, " high cycles per period"}, ones, hs * (f + 1));
      else
        check(ones > 0 && ones < pc, {rq, " mixed levels"}, ones, pc / 2);
    end

    // R1: reset in the middle of a noise run
    wr(2'd0, 5'd8);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(amp == 4'd0, "R1 mid-run reset", amp, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(amp == 4'd0, "R1 volume cleared", amp, 0);
    wr(2'd2, 5'd7); @(negedge clk);
    check(amp == 4'd7, "R1 select cleared to constant", amp, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule